// File: doc/BRIEF.md
# DDR2 Mode Register with DLL-Reset Read Lockout

This block holds the mode-register state of a DDR2-style memory device or controller. A load strobe carries a 14-bit command word. When bit 7 of the word is 0, the block latches the burst type, the burst length and the remaining option bits from that word. When bit 7 is 1, the word asks for a vendor test mode that is not supported. The block then changes nothing and raises a one-cycle flag.

Bit 8 of a normal load requests a DLL reset. The stored DLL-reset bit reads 1 for exactly one cycle and then clears itself. The same load starts a lockout of `LOCK_CYC` clocks (200 by default), during which READ requests are refused. A refused request produces a one-cycle error pulse. A request made outside the lockout is passed on as a one-cycle grant. A controller uses `rd_ok` to hold back reads, and uses `rd_early` to catch reads that break the DLL settling time.

Top module: `ddr_mode_reg`

## Requirements
- R1: After synchronous reset, `burst_il`=0 (sequential), `burst_len8`=0 (length 4), `opt_bits`=0, `rd_ok`=1, and `dll_bit`, `tm_flag`, `len_err`, `rd_grant`, `rd_early` are all 0.
- R2: On a normal load (word bit 7 = 0), word bit 3 is stored in `burst_il` (0 = sequential, 1 = interleaved). Word bits 13:9 and 6:4 are stored in `opt_bits` as {bits 13:9, bits 6:4}. Both are visible on the cycle after the load.
- R3: On a normal load, word bits 2:0 = 3'b010 set length 4 (`burst_len8`=0), and 3'b011 set length 8 (`burst_len8`=1). Any other code leaves `burst_len8` unchanged and pulses `len_err` for one cycle on the next cycle.
- R4: A load with word bit 7 = 1 changes no field and starts no DLL reset. It pulses `tm_flag` for one cycle on the next cycle.
- R5: A normal load with word bit 8 = 1 makes `dll_bit` read 1 on the next cycle only. It then reads 0 again.
- R6: After a DLL-reset load, `rd_ok` is 0 for the next 200 cycles and returns to 1 on the cycle after that.
- R7: A read request while `rd_ok`=0 gives a one-cycle `rd_early` pulse on the next cycle and no grant. A read request while `rd_ok`=1 gives a one-cycle `rd_grant` on the next cycle.
- R8: A DLL-reset load made during an active lockout restarts the full 200-cycle count from that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld | input | 1 | Mode-register load strobe |
| ld_word | input | 14 | Word carried by the load |
| rd_req | input | 1 | Read request strobe |
| burst_il | output | 1 | Burst type: 0 sequential, 1 interleaved |
| burst_len8 | output | 1 | Burst length: 0 four beats, 1 eight beats |
| opt_bits | output | 8 | Other option bits {word[13:9], word[6:4]} |
| dll_bit | output | 1 | Self-clearing DLL-reset bit |
| tm_flag | output | 1 | Pulse: unsupported test-mode load ignored |
| len_err | output | 1 | Pulse: invalid burst-length code |
| rd_ok | output | 1 | Reads currently allowed |
| rd_grant | output | 1 | Pulse: read accepted |
| rd_early | output | 1 | Pulse: read refused during lockout |

## Verification
Every result registers one clock after its stimulus. Latched fields, `dll_bit`, `tm_flag`, `len_err`, `rd_grant` and `rd_early` all change at the first rising edge after the strobe. `rd_ok` drops at that same edge and rises 200 edges later. The bench drives inputs just after a falling edge and advances a behavioural model on each rising edge. It compares every output at each following falling edge, when the design has settled. Directed checks then sample `rd_ok` at exactly the 200th and 201st falling edges after a DLL-reset load, including after a restart.

// File: rtl/ddr_mode_reg.sv
module ddr_mode_reg #(
  parameter int WORD_W   = 14,
  parameter int LOCK_CYC = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              rd_req,
  output logic              burst_il,
  output logic              burst_len8,
  output logic [WORD_W-7:0] opt_bits,
  output logic              dll_bit,
  output logic              tm_flag,
  output logic              len_err,
  output logic              rd_ok,
  output logic              rd_grant,
  output logic              rd_early
);
  localparam int CW = $clog2(LOCK_CYC + 1);

  logic [CW-1:0] lock_cnt;

  wire norm_ld = ld && !ld_word[7];
  wire dll_ld  = norm_ld && ld_word[8];
  wire code4   = ld_word[2:0] == 3'b010;
  wire code8   = ld_word[2:0] == 3'b011;

  assign rd_ok = lock_cnt == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_il   <= 1'b0;
      burst_len8 <= 1'b0;
      opt_bits   <= '0;
      dll_bit    <= 1'b0;
      tm_flag    <= 1'b0;
      len_err    <= 1'b0;
      rd_grant   <= 1'b0;
      rd_early   <= 1'b0;
      lock_cnt   <= '0;
    end else begin
      rd_grant <= rd_req && rd_ok;
      rd_early <= rd_req && !rd_ok;
      tm_flag  <= ld && ld_word[7];
      len_err  <= norm_ld && !(code4 || code8);
      dll_bit  <= dll_ld;
      if (norm_ld) begin
        burst_il <= ld_word[3];
        opt_bits <= {ld_word[WORD_W-1:9], ld_word[6:4]};
        if (code4)      burst_len8 <= 1'b0;
        else if (code8) burst_len8 <= 1'b1;
      end
      if (dll_ld)             lock_cnt <= CW'(LOCK_CYC);
      else if (lock_cnt != 0) lock_cnt <= lock_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ddr_mode_reg_chk.sv
module ddr_mode_reg_chk #(
  parameter int WORD_W   = 14,
  parameter int LOCK_CYC = 200
) (
  input logic              clk,
  input logic              rst,
  input logic              ld,
  input logic [WORD_W-1:0] ld_word,
  input logic              rd_req,
  input logic              burst_il,
  input logic              burst_len8,
  input logic              dll_bit,
  input logic              tm_flag,
  input logic              len_err,
  input logic              rd_ok,
  input logic              rd_grant,
  input logic              rd_early
);
  int since;
  wire dll_in = ld && !ld_word[7] && ld_word[8];
  wire bad_code = ld_word[2:0] != 3'b010 && ld_word[2:0] != 3'b011;

  always_ff @(posedge clk) begin
    if (rst)                 since <= LOCK_CYC;
    else if (dll_in)         since <= 0;
    else if (since < LOCK_CYC) since <= since + 1;
  end

  p_window_r6: assert property (@(posedge clk) disable iff (rst)
    rd_ok == (since == LOCK_CYC));
  p_self_clear_r5: assert property (@(posedge clk) disable iff (rst)
    dll_bit |=> !dll_bit);
  p_test_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ld && ld_word[7] |=> tm_flag && !dll_bit &&
      burst_il == $past(burst_il) && burst_len8 == $past(burst_len8));
  p_bad_len_r3: assert property (@(posedge clk) disable iff (rst)
    ld && !ld_word[7] && bad_code |=> len_err && burst_len8 == $past(burst_len8));
  p_early_r7: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ok |=> rd_early && !rd_grant);
  p_grant_r7: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_ok |=> rd_grant && !rd_early);
  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    dll_in |=> !rd_ok);
endmodule

bind ddr_mode_reg ddr_mode_reg_chk #(.WORD_W(WORD_W), .LOCK_CYC(LOCK_CYC)) i_chk (
  .clk(clk), .rst(rst), .ld(ld), .ld_word(ld_word), .rd_req(rd_req),
  .burst_il(burst_il), .burst_len8(burst_len8), .dll_bit(dll_bit),
  .tm_flag(tm_flag), .len_err(len_err), .rd_ok(rd_ok),
  .rd_grant(rd_grant), .rd_early(rd_early));

// File: tb/test_ddr_mode_reg.sv
module test_ddr_mode_reg;
  logic clk = 0, rst = 1, ld = 0, rd_req = 0;
  logic [13:0] ld_word = '0;
  logic burst_il, burst_len8, dll_bit, tm_flag, len_err, rd_ok, rd_grant, rd_early;
  logic [7:0] opt_bits;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ddr_mode_reg i_ddr_mode_reg (.*);

  // behavioural reference
  int m_lock = 0;
  bit m_il, m_l8, m_dll, m_tm, m_lerr, m_gr, m_ea;
  logic [7:0] m_opt;
  always @(posedge clk) begin
    if (rst) begin
      m_lock = 0; m_il = 0; m_l8 = 0; m_opt = 0;
      m_dll = 0; m_tm = 0; m_lerr = 0; m_gr = 0; m_ea = 0;
    end else begin
      m_gr = rd_req && (m_lock == 0);
      m_ea = rd_req && (m_lock != 0);
      m_dll = 0; m_tm = 0; m_lerr = 0;
      if (m_lock > 0) m_lock--;
      if (ld) begin
        if (ld_word[7]) m_tm = 1;
        else begin
          m_il = ld_word[3];
          m_opt = {ld_word[13:9], ld_word[6:4]};
          if (ld_word[2:0] == 3'd2) m_l8 = 0;
          else if (ld_word[2:0] == 3'd3) m_l8 = 1;
          else m_lerr = 1;
          if (ld_word[8]) begin m_dll = 1; m_lock = 200; end
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R2 burst_il", burst_il, m_il);
    chk("R2 opt_bits", opt_bits, m_opt);
    chk("R3 burst_len8", burst_len8, m_l8);
    chk("R3 len_err", len_err, m_lerr);
    chk("R4 tm_flag", tm_flag, m_tm);
    chk("R5 dll_bit", dll_bit, m_dll);
    chk("R6 rd_ok", rd_ok, m_lock == 0);
    chk("R7 rd_grant", rd_grant, m_gr);
    chk("R7 rd_early", rd_early, m_ea);
  end

  task automatic load(input logic [13:0] w);
    ld = 1; ld_word = w; @(negedge clk); #1 ld = 0;
  endtask

  task automatic read1();
    rd_req = 1; @(negedge clk); #1 rd_req = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    chk("R1 burst_il", burst_il, 0);
    chk("R1 burst_len8", burst_len8, 0);
    chk("R1 rd_ok", rd_ok, 1);
    chk("R1 dll_bit", dll_bit, 0);
    chk("R1 rd_early", rd_early, 0);
    @(negedge clk); #1;
    load(14'h0003);                       // seq, len 8
    chk("R3 len8", burst_len8, 1);
    load(14'h3E7A);                       // interleaved, len 4, opt bits
    chk("R2 interleaved", burst_il, 1);
    chk("R2 opt", opt_bits, 8'hFF);
    load(14'h0005);                       // bad code, sequential
    chk("R3 kept len", burst_len8, 0);
    chk("R3 len_err", len_err, 1);
    load(14'h0003);
    load(14'h018A);                       // test mode with dll bit
    chk("R4 unchanged len", burst_len8, 1);
    chk("R4 unchanged type", burst_il, 0);
    chk("R4 no lockout", rd_ok, 1);
    read1();
    chk("R7 grant", rd_grant, 1);
    load(14'h010B);                       // dll reset
    chk("R5 dll_bit set", dll_bit, 1);
    @(negedge clk); #1;
    chk("R5 dll_bit cleared", dll_bit, 0);
    read1();
    chk("R7 early", rd_early, 1);
    repeat (147) @(negedge clk); #1;      // 150 cycles into lockout
    load(14'h0103);                       // restart
    repeat (199) @(negedge clk); #1;
    chk("R8 still locked at 200th", rd_ok, 0);
    read1();
    chk("R8 early after restart", rd_early, 1);
    chk("R6 open after 200", rd_ok, 1);
    read1();
    chk("R6 grant after lockout", rd_grant, 1);
    load(14'h0102);
    repeat (199) @(negedge clk); #1;
    chk("R6 locked at 200", rd_ok, 0);
    @(negedge clk); #1;
    chk("R6 open at 201", rd_ok, 1);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule